// File: doc/BRIEF.md
# Two-Wire Slave Channel Configuration Register

This block is the slave end of a two-wire serial bus (clock plus open-drain data). It holds one 8-bit configuration word. One bit of that word sets which way a downstream clock buffer points. Four bits, one per channel, open or close four downstream bus branches. The two bus lines are brought into the system clock domain, and every bus event is decoded from the resulting edges.

A master opens a transfer with a START and then sends a 7-bit address, most significant bit first. The upper four bits of the address are the constant 1110 and the lower three bits come from strap pins. The address is followed by a direction bit. On a match the slave acknowledges by pulling the data line low. After that, the slave either accepts one data byte, which it acknowledges, or it returns the configuration word. A written byte only reaches the outputs when the STOP that ends the transfer is seen. A START that arrives first throws the written byte away. The data line is never pulled directly; `sda_pull_o` high asks the pad to pull it low.

Top module: `chanmux_cfg_slave`

## Requirements
- R1: The address byte is accepted when its first seven bits, most significant first, equal 1,1,1,0,strap[2],strap[1],strap[0]. The slave then holds the data line low through the ninth clock. On any other address the data line is left high during the ninth clock.
- R2: The eighth bit of the address byte selects the direction. 0 means the master writes the word. 1 means the slave sends the word.
- R3: The configuration word uses bit 7 as `clk_dir_o`, bits 6:4 as unused, and bit n as `chan_en_o[n]` for n = 0..3.
- R4: A read sends the word most significant bit first, with bits 6:4 always sent as 0.
- R5: A written byte changes `chan_en_o` and `clk_dir_o` only after a STOP (data rising while clock high). Before the STOP the outputs keep their old value.
- R6: The first data byte of a write is acknowledged (data low in its ninth clock). Any further byte in the same transfer is not acknowledged and is discarded. After the read byte, the slave leaves the data line released for the master's not-acknowledge and STOP.
- R7: Reset (`rst_n` low) clears the word to 0x00: all channels off and `clk_dir_o` = 0.
- R8: A START (data falling while clock high) is recognised in any state. A START that comes before the STOP cancels a written byte still waiting for its STOP.
- R9: After an address mismatch the slave never pulls the data line until the next START. A read at a foreign address therefore returns 0xFF and its own bytes go unacknowledged.
- R10: `sda_pull_o` changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| strap_i | input | 3 | Low three address bits from board straps |
| sda_pull_o | output | 1 | 1 = pull the data line low |
| chan_en_o | output | 4 | Per-channel enable, bit n for channel n |
| clk_dir_o | output | 1 | Clock buffer direction, 0 = forward |

## Verification
A vector table covers matching addresses with several strap settings and written values. It mixes in addresses that differ in the strap bits and addresses that differ in the fixed nibble, so an ignored transfer can be told from one that was acted on. Each write is followed by a readback. Writes that set the unused bits 6:4 separate read masking from storage. Directed transfers then cover the following cases:
- sampling the outputs between the data acknowledge and the STOP, to separate commit-at-STOP from commit-on-byte;
- a repeated START after a written byte, to show it is discarded;
- a second data byte in one write;
- a read at a foreign address;
- a reset in the middle of operation.

// File: rtl/cms_pkg.sv
package cms_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WR,
        ST_WACK,
        ST_RD,
        ST_RACK,
        ST_IGN
    } bus_st_e;

    typedef struct packed {
        bus_st_e             st;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   sh;
        logic                pull;
        logic                pend_v;
        logic [BYTE_W-1:0]   pend;
    } fsm_s;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int W = STAGES + 1;

    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[W-2:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= sr_d;
    end

    assign lvl_o  = sr_q[STAGES-1];
    assign rise_o = sr_q[STAGES-1] & ~sr_q[STAGES];
    assign fall_o = ~sr_q[STAGES-1] & sr_q[STAGES];
endmodule

// File: rtl/twi_cfg_reg.sv
module twi_cfg_reg #(
    parameter int NUM_CH  = 4,
    parameter int DIR_BIT = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit_i,
    input  logic [cms_pkg::BYTE_W-1:0] wdata_i,
    output logic [cms_pkg::BYTE_W-1:0] rd_val_o,
    output logic [NUM_CH-1:0]         chan_en_o,
    output logic                      clk_dir_o
);
    logic [NUM_CH-1:0] ch_d, ch_q;
    logic              dir_d, dir_q;

    always_comb begin
        ch_d  = ch_q;
        dir_d = dir_q;
        if (commit_i) begin
            ch_d  = wdata_i[NUM_CH-1:0];
            dir_d = wdata_i[DIR_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q  <= '0;
            dir_q <= 1'b0;
        end else begin
            ch_q  <= ch_d;
            dir_q <= dir_d;
        end
    end

    always_comb begin
        rd_val_o                = '0;
        rd_val_o[NUM_CH-1:0]    = ch_q;
        rd_val_o[DIR_BIT]       = dir_q;
    end

    assign chan_en_o = ch_q;
    assign clk_dir_o = dir_q;
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm #(
    parameter int         HI_W    = 4,
    parameter logic [3:0] ADDR_HI = 4'b1110,
    parameter int         DIR_BIT = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic                       stop_i,
    input  logic                       scl_rise_i,
    input  logic                       scl_fall_i,
    input  logic                       sda_lvl_i,
    input  logic [6-HI_W:0]            strap_i,
    input  logic [cms_pkg::BYTE_W-1:0] rd_val_i,
    output logic                       pull_o,
    output logic                       commit_o,
    output logic [cms_pkg::BYTE_W-1:0] wdata_o,
    output logic                       pend_v_o,
    output logic                       ignoring_o
);
    import cms_pkg::*;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);
    localparam fsm_s FSM_RST = '{st: ST_IDLE, cnt: '0, sh: '0,
                                 pull: 1'b0, pend_v: 1'b0, pend: '0};

    fsm_s q, d;
    logic addr_hit;

    assign addr_hit = (q.sh[BYTE_W-1:1] == {ADDR_HI[HI_W-1:0], strap_i});

    always_comb begin
        d        = q;
        commit_o = 1'b0;
        if (start_i) begin
            d.st     = ST_ADDR;
            d.cnt    = '0;
            d.pull   = 1'b0;
            d.pend_v = 1'b0;
        end else if (stop_i) begin
            commit_o = q.pend_v;
            d.st     = ST_IDLE;
            d.pull   = 1'b0;
            d.pend_v = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR: begin
                    if (scl_rise_i) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_lvl_i};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall_i && q.cnt == LAST) begin
                        if (addr_hit) begin
                            d.pull = 1'b1;
                            d.st   = ST_AACK;
                        end else begin
                            d.st   = ST_IGN;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall_i) begin
                        d.cnt = '0;
                        if (q.sh[0]) begin
                            d.sh   = rd_val_i;
                            d.pull = ~rd_val_i[BYTE_W-1];
                            d.st   = ST_RD;
                        end else begin
                            d.pull = 1'b0;
                            d.st   = ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise_i) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_lvl_i};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall_i && q.cnt == LAST) begin
                        d.pull   = 1'b1;
                        d.pend   = q.sh;
                        d.pend_v = 1'b1;
                        d.st     = ST_WACK;
                    end
                end
                ST_WACK: begin
                    if (scl_fall_i) begin
                        d.pull = 1'b0;
                        d.st   = ST_IGN;
                    end
                end
                ST_RD: begin
                    if (scl_rise_i) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall_i) begin
                        if (q.cnt == LAST) begin
                            d.pull = 1'b0;
                            d.st   = ST_RACK;
                        end else begin
                            d.sh   = q.sh << 1;
                            d.pull = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise_i) d.st = ST_IGN;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= FSM_RST;
        else        q <= d;
    end

    assign pull_o     = q.pull;
    assign wdata_o    = q.pend;
    assign pend_v_o   = q.pend_v;
    assign ignoring_o = (q.st == ST_IGN);
endmodule

// File: rtl/chanmux_cfg_slave.sv
module chanmux_cfg_slave #(
    parameter int         NUM_CH      = 4,
    parameter int         SYNC_STAGES = 2,
    parameter int         HI_W        = 4,
    parameter logic [3:0] ADDR_HI     = 4'b1110,
    parameter int         DIR_BIT     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [6-HI_W:0]   strap_i,
    output logic              sda_pull_o,
    output logic [NUM_CH-1:0] chan_en_o,
    output logic              clk_dir_o
);
    import cms_pkg::*;

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw, lvl, rise, fall;
    logic              scl_lvl, start_det, stop_det;
    logic              commit, pend_valid, ignoring;
    logic [BYTE_W-1:0] wdata, rd_val;

    assign raw = {sda_i, scl_i};

    for (genvar i = 0; i < NLINES; i++) begin : g_sync
        twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw[i]),
            .lvl_o  (lvl[i]),
            .rise_o (rise[i]),
            .fall_o (fall[i])
        );
    end

    assign scl_lvl   = lvl[0];
    assign start_det = fall[1] & lvl[0];
    assign stop_det  = rise[1] & lvl[0];

    twi_slave_fsm #(.HI_W(HI_W), .ADDR_HI(ADDR_HI), .DIR_BIT(DIR_BIT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .scl_rise_i (rise[0]),
        .scl_fall_i (fall[0]),
        .sda_lvl_i  (lvl[1]),
        .strap_i    (strap_i),
        .rd_val_i   (rd_val),
        .pull_o     (sda_pull_o),
        .commit_o   (commit),
        .wdata_o    (wdata),
        .pend_v_o   (pend_valid),
        .ignoring_o (ignoring)
    );

    twi_cfg_reg #(.NUM_CH(NUM_CH), .DIR_BIT(DIR_BIT)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit),
        .wdata_i   (wdata),
        .rd_val_o  (rd_val),
        .chan_en_o (chan_en_o),
        .clk_dir_o (clk_dir_o)
    );
endmodule

// File: rtl/chanmux_cfg_slave_chk.sv
module chanmux_cfg_slave_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_hi,
    input logic              sda_pull_o,
    input logic [NUM_CH-1:0] chan_en_o,
    input logic              clk_dir_o,
    input logic              start_det,
    input logic              pend_valid,
    input logic              stop_det,
    input logic              ignoring
);
    // R7: reset leaves all outputs cleared
    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (chan_en_o == '0 && !clk_dir_o));

    // R5: outputs move only right after a STOP
    p_commit_on_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en_o != $past(chan_en_o) || clk_dir_o != $past(clk_dir_o)) |-> $past(stop_det));

    // R8: START drops any waiting byte
    p_start_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_det) |-> !pend_valid);

    // R9: foreign transfer never pulls the line
    p_ignore_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ignoring |-> !sda_pull_o);

    // R10: drive steady while the clock stays high
    p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hi && $past(scl_hi)) |-> $stable(sda_pull_o));
endmodule

bind chanmux_cfg_slave chanmux_cfg_slave_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_hi     (scl_lvl),
    .sda_pull_o (sda_pull_o),
    .chan_en_o  (chan_en_o),
    .clk_dir_o  (clk_dir_o),
    .start_det  (start_det),
    .pend_valid (pend_valid),
    .stop_det   (stop_det),
    .ignoring   (ignoring)
);

// File: tb/chanmux_cfg_slave_bench.sv
module chanmux_cfg_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 10;
    localparam int MAX_CYC    = 150000;
    localparam int NVEC       = 8;

    // {strap[2:0], addr[6:0], wdata[7:0], expect_ack, expect_word[7:0]}
    localparam logic [26:0] VEC [NVEC] = '{
        {3'd0, 7'h70, 8'h0A, 1'b1, 8'h0A},
        {3'd0, 7'h71, 8'hFF, 1'b0, 8'h0A},
        {3'd5, 7'h75, 8'hF5, 1'b1, 8'h85},
        {3'd5, 7'h70, 8'h00, 1'b0, 8'h85},
        {3'd3, 7'h73, 8'h70, 1'b1, 8'h00},
        {3'd7, 7'h77, 8'h8F, 1'b1, 8'h8F},
        {3'd7, 7'h67, 8'h01, 1'b0, 8'h8F},
        {3'd2, 7'h72, 8'h03, 1'b1, 8'h03}
    };

    logic       clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
    logic [2:0] strap = 3'd0;
    logic       sda_pull, clk_dir;
    logic [3:0] chan;
    wire        sda_line = sda_m & ~sda_pull;

    int checks = 0, fails = 0, r10_viol = 0;
    logic scl_p = 1'b1, pull_p = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chanmux_cfg_slave u_chanmux_cfg_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .strap_i    (strap),
        .sda_pull_o (sda_pull),
        .chan_en_o  (chan),
        .clk_dir_o  (clk_dir)
    );

    always @(negedge clk) begin
        if (rst_n && scl_m && scl_p && sda_pull != pull_p) r10_viol++;
        scl_p  <= scl_m;
        pull_p <= sda_pull;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq;
        repeat (QTR) @(posedge clk);
        #1;
    endtask

    task automatic xfer_bit(input logic b, output logic r);
        sda_m = b; wq();
        scl_m = 1'b1; wq();
        @(negedge clk) r = sda_line;
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic nak);
        logic r;
        for (int i = 7; i >= 0; i--) xfer_bit(v[i], r);
        xfer_bit(1'b1, nak);
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic mnak, output logic line);
        for (int i = 7; i >= 0; i--) xfer_bit(1'b1, v[i]);
        xfer_bit(mnak, line);
    endtask

    task automatic write_reg(input logic [6:0] a, input logic [7:0] dv,
                             output logic an, output logic dn);
        bus_start();
        send_byte({a, 1'b0}, an);
        send_byte(dv, dn);
        bus_stop();
        wq();
    endtask

    task automatic read_reg(input logic [6:0] a, output logic [7:0] v,
                            output logic an, output logic nl);
        bus_start();
        send_byte({a, 1'b1}, an);
        recv_byte(v, 1'b1, nl);
        bus_stop();
        wq();
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=expired expected=done");
        summary();
        $finish;
    end

    initial begin
        logic an, dn, nl, an2;
        logic [7:0] rv;

        // R7: reset state
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R7 reset outputs", {clk_dir, chan}, 0);
        chk("R7 reset no pull", sda_pull, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        wq();

        for (int k = 0; k < NVEC; k++) begin
            logic [26:0] v;
            v = VEC[k];
            strap = v[26:24];
            wq();
            write_reg(v[23:17], v[16:9], an, dn);
            chk($sformatf("R1 addr ack vec%0d", k), an, !v[8]);
            if (v[8]) chk($sformatf("R6 data ack vec%0d", k), dn, 0);
            else      chk($sformatf("R9 no data ack vec%0d", k), dn, 1);
            chk($sformatf("R3 R5 outputs vec%0d", k), {clk_dir, chan}, {v[7], v[3:0]});
            read_reg({4'hE, strap}, rv, an, nl);
            chk($sformatf("R2 read ack vec%0d", k), an, 0);
            chk($sformatf("R4 readback vec%0d", k), rv, v[7:0]);
            chk($sformatf("R6 master nack free vec%0d", k), nl, 1);
        end

        // R5: outputs hold until STOP (strap 2, word 0x03)
        bus_start();
        send_byte({7'h72, 1'b0}, an);
        send_byte(8'h0C, dn);
        wq(); wq();
        chk("R5 before stop", {clk_dir, chan}, 5'h03);
        bus_stop();
        wq();
        chk("R5 after stop", {clk_dir, chan}, 5'h0C);

        // R8: repeated START discards waiting byte
        bus_start();
        send_byte({7'h72, 1'b0}, an);
        send_byte(8'h81, dn);
        chk("R8 byte acked", dn, 0);
        bus_start();
        send_byte({7'h72, 1'b1}, an);
        recv_byte(rv, 1'b1, nl);
        bus_stop();
        wq();
        chk("R8 readback old", rv, 8'h0C);
        chk("R8 outputs old", {clk_dir, chan}, 5'h0C);

        // R6: second data byte not acked and discarded
        bus_start();
        send_byte({7'h72, 1'b0}, an);
        send_byte(8'h05, dn);
        send_byte(8'h0F, an2);
        bus_stop();
        wq();
        chk("R6 first byte ack", dn, 0);
        chk("R6 second byte nack", an2, 1);
        chk("R6 outputs first byte", {clk_dir, chan}, 5'h05);

        // R9: read at foreign address returns all ones
        read_reg(7'h74, rv, an, nl);
        chk("R9 foreign addr nack", an, 1);
        chk("R9 foreign read", rv, 8'hFF);

        // R7: reset in operation
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 mid reset outputs", {clk_dir, chan}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        wq();
        read_reg(7'h72, rv, an, nl);
        chk("R7 readback after reset", rv, 0);

        // R10: no drive change while clock high
        chk("R10 drive while clock high", r10_viol, 0);

        summary();
        $finish;
    end
endmodule